// File: doc/BRIEF.md
# Channel Command Program Sequencer

This block runs a short program of command words stored in memory for a single attached device. Software writes a chain of 8-byte command words into memory and pulses a start request with the address of the first word. The block then fetches each word in turn, decodes it, and moves bytes between memory and one of four places: the device's outgoing data stream, the device's incoming data stream, the controller's command channel or the controller's status channel. A jump word redirects execution and a sense word can skip the word after it, so the descriptor list behaves as a small program rather than a flat list.

During a transfer the block keeps a live record of the current buffer address and the bytes still to move, and this record is visible on its outputs. When the program stops because a word lacks the chain flag, because an unknown command is met, or because the cancel input is raised, the block pulses an interrupt for one cycle and reports an end code.

Top module: `cmdprog_engine`

## Requirements
- R1: After reset `busy` and `irq` are low. A `start` pulse while idle latches `start_addr` as the first word address and raises `busy` on the next cycle. A `start` pulse while busy is ignored.
- R2: A command word is read from the fetch port and is valid on `fetch_data` one cycle after `fetch_req`. Bits 63:56 hold the command, 55:48 the flags, 47:16 the buffer address and 15:0 the byte count. Flags bit 0 set means continue with the word 8 bytes further on. If bit 0 is clear, the program ends after the word with end code 0.
- R3: Command 0x01 reads `len` bytes from memory starting at the buffer address, in increasing address order, and presents them on `dev_out_data` with `dev_out_valid`.
- R4: Command 0x02 takes `len` bytes from `dev_in_data`, one per `dev_in_pop`, and writes them to memory from the buffer address upward, unchanged.
- R5: Command 0x03 reads `len` bytes from memory and presents them on `ctl_out_data` with `ctl_out_valid`. Nothing goes to the data stream.
- R6: Command 0x04 takes `len` status bytes from `ctl_in_data`, one per `ctl_in_pop`, and writes them to memory from the buffer address upward.
- R7: Command 0x08 continues at the word found at its buffer address. Its flags and count are ignored, so it continues even when flags bit 0 is clear.
- R8: A command 0x04 word with flags bits 1 and 0 set skips the following word when `ctl_cond` is high once its bytes are done. The next word fetched is then 16 bytes on.
- R9: Each byte moved increments `rec_addr` by one and decrements `rec_len` by one. After a word has completed, `rec_addr` equals buffer address plus count and `rec_len` is 0.
- R10: A command value outside {0x01, 0x02, 0x03, 0x04, 0x08} ends the program without moving bytes, with end code 1.
- R11: A high `cancel` while busy ends the program once the byte in flight has moved, with end code 2. The record then shows exactly the bytes moved.
- R12: At the end `irq` is high for exactly one cycle, `busy` falls with it, and `done_code` holds the end code. A word with count 0 moves no bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start request |
| start_addr | input | ADDR_W | Address of the first command word |
| cancel | input | 1 | Stop request |
| busy | output | 1 | Program running |
| irq | output | 1 | One-cycle end pulse |
| done_code | output | 2 | 0 normal, 1 bad command, 2 cancelled |
| rec_addr | output | ADDR_W | Next buffer byte of the current word |
| rec_len | output | 16 | Bytes still to move for the current word |
| fetch_req | output | 1 | Command word read request |
| fetch_addr | output | ADDR_W | Command word address |
| fetch_data | input | 64 | Command word, one cycle after request |
| mem_rd | output | 1 | Byte read request |
| mem_wr | output | 1 | Byte write strobe |
| mem_addr | output | ADDR_W | Byte address |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Byte read, one cycle after request |
| dev_out_valid | output | 1 | Data byte to device |
| dev_out_data | output | 8 | Data byte value |
| dev_in_pop | output | 1 | Takes one byte from the device |
| dev_in_data | input | 8 | Device data byte |
| ctl_out_valid | output | 1 | Command byte to controller |
| ctl_out_data | output | 8 | Command byte value |
| ctl_in_pop | output | 1 | Takes one status byte |
| ctl_in_data | input | 8 | Controller status byte |
| ctl_cond | input | 1 | Controller condition for skip |

## Verification
The bench builds the block with a 10-bit address width. This lets a 1 KiB behavioural memory hold both the programs and the buffers, and it lets pointer and buffer arithmetic wrap at that width. With short byte counts, randomly drawn chains of up to six words mixing all five commands, jumps and skips stay well inside the run budget. A single long read gives the cancel case enough bytes in flight to land in the middle of a transfer.

// File: rtl/cps_pkg.sv
package cps_pkg;
  localparam int WORD_W = 64;
  localparam int LEN_W  = 16;
  localparam int STRIDE = 8;

  localparam logic [7:0] CMD_WRITE = 8'h01;
  localparam logic [7:0] CMD_READ  = 8'h02;
  localparam logic [7:0] CMD_CTL   = 8'h03;
  localparam logic [7:0] CMD_SENSE = 8'h04;
  localparam logic [7:0] CMD_JUMP  = 8'h08;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_FWAIT, S_XFER, S_MRD, S_MWAIT, S_NEXT, S_DONE
  } state_e;

  typedef enum logic [1:0] {K_WR, K_RD, K_CTL, K_SNS} kind_e;

  typedef enum logic [1:0] {END_OK = 2'd0, END_BADCMD = 2'd1, END_CANCEL = 2'd2} end_e;

  typedef struct packed {
    logic [7:0]       cmd;
    logic [7:0]       flags;
    logic [31:0]      buf_addr;
    logic [LEN_W-1:0] len;
  } word_t;

  function automatic logic flag_chain(input logic [7:0] f);
    return f[0];
  endfunction

  function automatic logic flag_skip(input logic [7:0] f);
    return f[1];
  endfunction

  function automatic logic [LEN_W-1:0] len_after_byte(input logic [LEN_W-1:0] l);
    return l - 1'b1;
  endfunction
endpackage

// File: rtl/cps_decode.sv
module cps_decode
  import cps_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [WORD_W-1:0] word,
  output logic [ADDR_W-1:0] buf_addr,
  output logic [LEN_W-1:0]  len,
  output logic              chain,
  output logic              skip_en,
  output logic              is_jump,
  output logic              is_bad,
  output logic              is_zero,
  output kind_e             kind
);
  word_t w;
  assign w        = word;
  assign buf_addr = w.buf_addr[ADDR_W-1:0];
  assign len      = w.len;
  assign chain    = flag_chain(w.flags);
  assign skip_en  = flag_skip(w.flags);
  assign is_zero  = (w.len == '0);

  always_comb begin
    is_jump = 1'b0;
    is_bad  = 1'b0;
    kind    = K_WR;
    unique case (w.cmd)
      CMD_WRITE: kind = K_WR;
      CMD_READ:  kind = K_RD;
      CMD_CTL:   kind = K_CTL;
      CMD_SENSE: kind = K_SNS;
      CMD_JUMP:  is_jump = 1'b1;
      default:   is_bad = 1'b1;
    endcase
  end
endmodule

// File: rtl/cps_next_ptr.sv
module cps_next_ptr
  import cps_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] ptr,
  input  logic              skip,
  output logic [ADDR_W-1:0] next
);
  localparam logic [ADDR_W-1:0] STEP1 = ADDR_W'(STRIDE);
  localparam logic [ADDR_W-1:0] STEP2 = ADDR_W'(2 * STRIDE);
  assign next = ptr + (skip ? STEP2 : STEP1);
endmodule

// File: rtl/cmdprog_engine.sv
module cmdprog_engine
  import cps_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              cancel,
  output logic              busy,
  output logic              irq,
  output logic [1:0]        done_code,
  output logic [ADDR_W-1:0] rec_addr,
  output logic [15:0]       rec_len,
  output logic              fetch_req,
  output logic [ADDR_W-1:0] fetch_addr,
  input  logic [63:0]       fetch_data,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  output logic              dev_out_valid,
  output logic [7:0]        dev_out_data,
  output logic              dev_in_pop,
  input  logic [7:0]        dev_in_data,
  output logic              ctl_out_valid,
  output logic [7:0]        ctl_out_data,
  output logic              ctl_in_pop,
  input  logic [7:0]        ctl_in_data,
  input  logic              ctl_cond
);
  state_e            st;
  kind_e             cur_kind;
  logic              cur_chain, cur_skip_en;
  logic [ADDR_W-1:0] ptr;
  logic [ADDR_W-1:0] cur_addr;
  logic [LEN_W-1:0]  cur_len;
  logic [1:0]        code_q;

  // decoded view of the fetched word
  logic [ADDR_W-1:0] d_addr;
  logic [LEN_W-1:0]  d_len;
  logic              d_chain, d_skip, d_jump, d_bad, d_zero;
  kind_e             d_kind;

  cps_decode #(.ADDR_W(ADDR_W)) u_dec (
    .word     (fetch_data),
    .buf_addr (d_addr),
    .len      (d_len),
    .chain    (d_chain),
    .skip_en  (d_skip),
    .is_jump  (d_jump),
    .is_bad   (d_bad),
    .is_zero  (d_zero),
    .kind     (d_kind)
  );

  logic              take_skip;
  logic [ADDR_W-1:0] ptr_next;
  assign take_skip = (cur_kind == K_SNS) && cur_skip_en && ctl_cond;

  cps_next_ptr #(.ADDR_W(ADDR_W)) u_nxt (
    .ptr  (ptr),
    .skip (take_skip),
    .next (ptr_next)
  );

  // named events for the checker
  logic ev_byte, last_byte, cancel_hit, to_port;
  assign ev_byte    = (st == S_XFER) || (st == S_MWAIT);
  assign last_byte  = (cur_len == LEN_W'(1));
  assign to_port    = (d_kind == K_WR) || (d_kind == K_CTL);
  assign cancel_hit = cancel && (st == S_FETCH || st == S_FWAIT || st == S_XFER ||
                                 st == S_MWAIT || st == S_NEXT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      ptr         <= '0;
      cur_addr    <= '0;
      cur_len     <= '0;
      cur_kind    <= K_WR;
      cur_chain   <= 1'b0;
      cur_skip_en <= 1'b0;
      code_q      <= END_OK;
    end else begin
      unique case (st)
        S_IDLE: if (start) begin
          ptr <= start_addr;
          st  <= S_FETCH;
        end
        S_FETCH: begin
          if (cancel) begin
            code_q <= END_CANCEL;
            st     <= S_DONE;
          end else begin
            st <= S_FWAIT;
          end
        end
        S_FWAIT: begin
          if (cancel) begin
            code_q <= END_CANCEL;
            st     <= S_DONE;
          end else if (d_bad) begin
            code_q <= END_BADCMD;
            st     <= S_DONE;
          end else if (d_jump) begin
            ptr <= d_addr;
            st  <= S_FETCH;
          end else begin
            cur_addr    <= d_addr;
            cur_len     <= d_len;
            cur_kind    <= d_kind;
            cur_chain   <= d_chain;
            cur_skip_en <= d_skip;
            if (d_zero)       st <= S_NEXT;
            else if (to_port) st <= S_MRD;
            else              st <= S_XFER;
          end
        end
        S_XFER: begin
          cur_addr <= cur_addr + 1'b1;
          cur_len  <= len_after_byte(cur_len);
          if (cancel) begin
            code_q <= END_CANCEL;
            st     <= S_DONE;
          end else if (last_byte) begin
            st <= S_NEXT;
          end
        end
        S_MRD: st <= S_MWAIT;
        S_MWAIT: begin
          cur_addr <= cur_addr + 1'b1;
          cur_len  <= len_after_byte(cur_len);
          if (cancel) begin
            code_q <= END_CANCEL;
            st     <= S_DONE;
          end else if (last_byte) begin
            st <= S_NEXT;
          end else begin
            st <= S_MRD;
          end
        end
        S_NEXT: begin
          if (cancel) begin
            code_q <= END_CANCEL;
            st     <= S_DONE;
          end else if (!cur_chain) begin
            code_q <= END_OK;
            st     <= S_DONE;
          end else begin
            ptr <= ptr_next;
            st  <= S_FETCH;
          end
        end
        S_DONE: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy       = (st != S_IDLE);
  assign irq        = (st == S_DONE);
  assign done_code  = code_q;
  assign rec_addr   = cur_addr;
  assign rec_len    = cur_len;

  assign fetch_req  = (st == S_FETCH);
  assign fetch_addr = ptr;

  assign mem_rd     = (st == S_MRD);
  assign mem_wr     = (st == S_XFER);
  assign mem_addr   = cur_addr;
  assign mem_wdata  = (cur_kind == K_RD) ? dev_in_data : ctl_in_data;

  assign dev_in_pop = (st == S_XFER) && (cur_kind == K_RD);
  assign ctl_in_pop = (st == S_XFER) && (cur_kind == K_SNS);

  assign dev_out_valid = (st == S_MWAIT) && (cur_kind == K_WR);
  assign ctl_out_valid = (st == S_MWAIT) && (cur_kind == K_CTL);
  assign dev_out_data  = mem_rdata;
  assign ctl_out_data  = mem_rdata;
endmodule

// File: rtl/cps_checker.sv
module cps_checker #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              irq,
  input logic              cancel_hit,
  input logic              ev_byte,
  input logic [ADDR_W-1:0] rec_addr,
  input logic [15:0]       rec_len,
  input logic              fetch_req,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic              dev_in_pop,
  input logic              ctl_in_pop,
  input logic [1:0]        done_code
);
  assert_start_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy);

  assert_one_access_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fetch_req, mem_rd, mem_wr}));

  assert_single_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> (dev_in_pop ^ ctl_in_pop));

  assert_record_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_byte |=> (rec_len == $past(rec_len) - 16'd1) &&
                (rec_addr == $past(rec_addr) + 1'b1));

  assert_bad_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (done_code != 2'd3));

  assert_cancel_end_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cancel_hit |=> (irq && done_code == 2'd2));

  assert_irq_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> (!irq && !busy));
endmodule

bind cmdprog_engine cps_checker #(.ADDR_W(ADDR_W)) u_cps_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .busy       (busy),
  .irq        (irq),
  .cancel_hit (cancel_hit),
  .ev_byte    (ev_byte),
  .rec_addr   (rec_addr),
  .rec_len    (rec_len),
  .fetch_req  (fetch_req),
  .mem_rd     (mem_rd),
  .mem_wr     (mem_wr),
  .dev_in_pop (dev_in_pop),
  .ctl_in_pop (ctl_in_pop),
  .done_code  (done_code)
);

// File: tb/cmdprog_engine_bench.sv
`timescale 1ns/1ps
module cmdprog_engine_bench;
  localparam int AW   = 10;
  localparam int MSZ  = 1 << AW;
  localparam int MASK = MSZ - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          start = 1'b0, cancel = 1'b0, ctl_cond = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic          busy, irq;
  logic [1:0]    done_code;
  logic [AW-1:0] rec_addr, fetch_addr, mem_addr;
  logic [15:0]   rec_len;
  logic          fetch_req, mem_rd, mem_wr;
  logic [63:0]   fetch_data = '0;
  logic [7:0]    mem_wdata, mem_rdata = '0;
  logic          dev_out_valid, dev_in_pop, ctl_out_valid, ctl_in_pop;
  logic [7:0]    dev_out_data, dev_in_data, ctl_out_data, ctl_in_data;

  cmdprog_engine #(.ADDR_W(AW)) u_cmdprog_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .cancel(cancel), .busy(busy), .irq(irq), .done_code(done_code),
    .rec_addr(rec_addr), .rec_len(rec_len),
    .fetch_req(fetch_req), .fetch_addr(fetch_addr), .fetch_data(fetch_data),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .dev_out_valid(dev_out_valid), .dev_out_data(dev_out_data),
    .dev_in_pop(dev_in_pop), .dev_in_data(dev_in_data),
    .ctl_out_valid(ctl_out_valid), .ctl_out_data(ctl_out_data),
    .ctl_in_pop(ctl_in_pop), .ctl_in_data(ctl_in_data),
    .ctl_cond(ctl_cond)
  );

  logic [7:0] mem  [0:MSZ-1];
  logic [7:0] smem [0:MSZ-1];
  logic [7:0] din  [0:255];
  logic [7:0] sin  [0:255];
  logic [7:0] got_dev [0:1023];
  logic [7:0] got_ctl [0:1023];
  logic [7:0] exp_dev [0:1023];
  logic [7:0] exp_ctl [0:1023];
  int din_i = 0, sin_i = 0, n_dev = 0, n_ctl = 0;
  int exp_nd, exp_nc;
  logic clr = 1'b0;
  int checks = 0, fails = 0;

  assign dev_in_data = din[din_i[7:0]];
  assign ctl_in_data = sin[sin_i[7:0]];

  function automatic logic [63:0] word_of(input int a, input bit shadow);
    logic [63:0] w = '0;
    for (int k = 0; k < 8; k++)
      w = {w[55:0], shadow ? smem[(a + k) & MASK] : mem[(a + k) & MASK]};
    return w;
  endfunction

  always @(posedge clk) begin
    if (fetch_req) fetch_data <= word_of(int'(fetch_addr), 1'b0);
    if (mem_rd)    mem_rdata  <= mem[mem_addr];
    if (mem_wr)    mem[mem_addr] = mem_wdata;
    if (clr) begin
      din_i <= 0; sin_i <= 0; n_dev <= 0; n_ctl <= 0;
    end else begin
      if (dev_in_pop) din_i <= din_i + 1;
      if (ctl_in_pop) sin_i <= sin_i + 1;
      if (dev_out_valid) begin got_dev[n_dev[9:0]] <= dev_out_data; n_dev <= n_dev + 1; end
      if (ctl_out_valid) begin got_ctl[n_ctl[9:0]] <= ctl_out_data; n_ctl <= n_ctl + 1; end
    end
  end

  function automatic logic [63:0] mkw(input logic [7:0] c, input logic [7:0] f,
                                      input int a, input int l);
    return {c, f, 32'(a), 16'(l)};
  endfunction

  task automatic put_word(input int a, input logic [63:0] w);
    for (int k = 0; k < 8; k++) begin
      mem[(a + k) & MASK]  = w[63 - 8*k -: 8];
      smem[(a + k) & MASK] = w[63 - 8*k -: 8];
    end
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Behavioural walk of a program over the shadow memory.
  task automatic model_run(input int sa, input bit cond, output int code);
    int p = sa & MASK;
    int di = 0, si = 0;
    exp_nd = 0; exp_nc = 0; code = 3;
    for (int step = 0; step < 64; step++) begin
      logic [63:0] w = word_of(p, 1'b1);
      logic [7:0]  c = w[63:56];
      logic [7:0]  f = w[55:48];
      int a  = int'(w[47:16]) & MASK;
      int ln = int'(w[15:0]);
      if (c == 8'h08) begin p = a; continue; end
      if (c != 8'h01 && c != 8'h02 && c != 8'h03 && c != 8'h04) begin code = 1; return; end
      for (int j = 0; j < ln; j++) begin
        int x = (a + j) & MASK;
        case (c)
          8'h01: begin exp_dev[exp_nd] = smem[x]; exp_nd++; end
          8'h03: begin exp_ctl[exp_nc] = smem[x]; exp_nc++; end
          8'h02: begin smem[x] = din[di]; di++; end
          default: begin smem[x] = sin[si]; si++; end
        endcase
      end
      if (!f[0]) begin code = 0; return; end
      p = (p + 8 + ((c == 8'h04 && f[1] && cond) ? 8 : 0)) & MASK;
    end
  endtask

  task automatic wait_irq(output bit seen);
    seen = 1'b0;
    for (int t = 0; t < 5000; t++) begin
      @(negedge clk);
      if (irq) begin seen = 1'b1; return; end
    end
    checks++; fails++;
    $display("FAIL R12 watchdog: actual=0 expected=1 (no irq)");
  endtask

  task automatic launch(input int sa, input bit cond);
    ctl_cond = cond;
    @(negedge clk) clr = 1'b1;
    @(negedge clk) begin clr = 1'b0; start = 1'b1; start_addr = AW'(sa); end
    @(negedge clk) start = 1'b0;
  endtask

  int last_code;

  task automatic run_prog(input int sa, input bit cond, input bit poke);
    int ecode; bit seen; bit ok;
    model_run(sa, cond, ecode);
    launch(sa, cond);
    if (poke) begin
      repeat (2) @(negedge clk);
      start = 1'b1; start_addr = AW'(8 * 30);
      @(negedge clk) start = 1'b0;
    end
    wait_irq(seen);
    if (!seen) return;
    last_code = int'(done_code);
    chk(done_code == 2'(ecode), "R12", "end code", int'(done_code), ecode);
    @(negedge clk);
    chk(!busy && !irq, "R12", "irq width", int'(irq), 0);
    chk(n_dev == exp_nd, "R3", "device out count", n_dev, exp_nd);
    ok = 1'b1;
    for (int j = 0; j < exp_nd && j < n_dev; j++) if (got_dev[j] !== exp_dev[j]) ok = 1'b0;
    chk(ok, "R3", "device out bytes", int'(ok), 1);
    chk(n_ctl == exp_nc, "R5", "controller out count", n_ctl, exp_nc);
    ok = 1'b1;
    for (int j = 0; j < exp_nc && j < n_ctl; j++) if (got_ctl[j] !== exp_ctl[j]) ok = 1'b0;
    chk(ok, "R5", "controller out bytes", int'(ok), 1);
    ok = 1'b1;
    for (int j = 256; j < MSZ; j++) if (mem[j] !== smem[j]) ok = 1'b0;
    chk(ok, "R4 R6", "memory image", int'(ok), 1);
  endtask

  task automatic clear_prog();
    for (int s = 0; s < 32; s++) put_word(8 * s, mkw(8'h01, 8'h00, 600, 0));
  endtask

  initial begin
    int code;
    bit seen;
    void'($urandom(32'd4242));
    for (int j = 0; j < MSZ; j++) begin
      mem[j] = 8'($urandom); smem[j] = mem[j];
    end
    for (int j = 0; j < 256; j++) begin din[j] = 8'($urandom); sin[j] = 8'($urandom); end
    repeat (3) @(negedge clk);
    chk(!busy && !irq, "R1", "reset state", int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: word without chain flag ends the program
    clear_prog();
    put_word(0, mkw(8'h01, 8'h00, 700, 1));
    put_word(8, mkw(8'h01, 8'h01, 710, 4));
    run_prog(0, 1'b0, 1'b0);
    chk(n_dev == 1, "R2", "stop without chain", n_dev, 1);

    // R7: jump without chain flag still continues
    clear_prog();
    put_word(0, mkw(8'h08, 8'h00, 40, 9));
    put_word(40, mkw(8'h01, 8'h00, 720, 3));
    run_prog(0, 1'b0, 1'b0);
    chk(n_dev == 3, "R7", "jump target run", n_dev, 3);

    // R8: skip taken and not taken
    for (int cnd = 0; cnd < 2; cnd++) begin
      clear_prog();
      put_word(0,  mkw(8'h04, 8'h03, 600, 1));
      put_word(8,  mkw(8'h01, 8'h01, 700, 2));
      put_word(16, mkw(8'h03, 8'h00, 710, 1));
      run_prog(0, cnd[0], 1'b0);
      chk(n_dev == (cnd ? 0 : 2), "R8", "skip of next word", n_dev, cnd ? 0 : 2);
    end

    // R10: unknown command
    clear_prog();
    put_word(0, mkw(8'h01, 8'h01, 730, 1));
    put_word(8, mkw(8'h55, 8'h01, 740, 4));
    run_prog(0, 1'b0, 1'b0);
    chk(last_code == 1 && n_dev == 1, "R10", "bad command end", last_code, 1);

    // R12: zero-length read moves nothing
    clear_prog();
    put_word(0, mkw(8'h02, 8'h00, 760, 0));
    run_prog(0, 1'b0, 1'b0);
    chk(din_i == 0 && rec_len == 0, "R12", "zero length", din_i, 0);

    // R9: record after a completed word
    clear_prog();
    put_word(0, mkw(8'h01, 8'h00, 650, 3));
    run_prog(0, 1'b0, 1'b0);
    chk(rec_addr == AW'(653) && rec_len == 0, "R9", "final record", int'(rec_addr), 653);

    // R1: start during a run is ignored
    clear_prog();
    put_word(8 * 30, mkw(8'h77, 8'h00, 0, 0));
    put_word(0, mkw(8'h02, 8'h00, 800, 20));
    run_prog(0, 1'b0, 1'b1);
    chk(last_code == 0 && din_i == 20, "R1", "start while busy", din_i, 20);

    // R11: cancel during a long read
    clear_prog();
    put_word(0, mkw(8'h02, 8'h00, 300, 200));
    launch(0, 1'b0);
    repeat (30) @(negedge clk);
    cancel = 1'b1;
    wait_irq(seen);
    cancel = 1'b0;
    if (seen) begin
      chk(done_code == 2'd2, "R11", "cancel code", int'(done_code), 2);
      chk(din_i > 0 && din_i < 200, "R11", "stopped mid transfer", din_i, 100);
      chk(int'(rec_len) + din_i == 200, "R11", "remaining count", int'(rec_len), 200 - din_i);
      chk(int'(rec_addr) == 300 + din_i, "R9", "cancel address", int'(rec_addr), 300 + din_i);
    end
    @(negedge clk);
    for (int j = 0; j < MSZ; j++) smem[j] = mem[j];

    // random programs
    for (int r = 0; r < 30; r++) begin
      int n = 2 + int'($urandom_range(4));
      clear_prog();
      for (int i = 0; i < n; i++) begin
        int sel = int'($urandom_range(4));
        logic [7:0] c, f;
        int a;
        case (sel)
          0: c = 8'h01; 1: c = 8'h02; 2: c = 8'h03; 3: c = 8'h04; default: c = 8'h08;
        endcase
        f = {6'd0, 1'($urandom), (i < n - 1) ? 1'b1 : 1'b0};
        a = (c == 8'h08) ? 8 * (i + 2) : 512 + int'($urandom_range(480));
        put_word(8 * i, mkw(c, f, a, int'($urandom_range(5))));
      end
      run_prog(0, 1'($urandom), 1'b0);
      for (int j = 0; j < MSZ; j++) smem[j] = mem[j];
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1500000;
    fails++;
    $display("FAIL R12 global watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule